// File: doc/BRIEF.md
# Minimal 8-bit Instruction Processor

This block is a small multi-cycle processor. It runs 8-bit instructions from a 16-entry internal program store. A simple write port fills that store. The processor has four 8-bit working registers, an arithmetic unit and conditional jumps, and it reaches the outside world in three ways:
- an 8-bit switch value that can be read into a register;
- an 8-bit display register;
- a flag that shows the processor has stopped.

Every instruction takes three clock cycles: fetch, operand read, and execute with write-back.

In use, the program store is loaded while reset is held. Reset is then released and the program runs until it reaches a stop instruction. The display register always shows the most recent value written to any register, or a register that an output instruction selects. Seven-segment decoding, debouncing and board pin assignment belong to the surrounding logic.

Top module: `mini8_core`

## Requirements
- R1: Synchronous reset sets the program counter, all four registers, both flags and the display to zero, clears the stopped flag and restarts at fetch; `display_o` reads 0 and `halted_o` reads 0 on the first cycle after a reset edge.
- R2: Each instruction takes exactly three rising edges after the previous one. The program counter and the display change only on the third edge. Instruction k after reset release completes on edge 3k.
- R3: The instruction bit fields, from bit 7 down, are opcode [7:6], function [5:4], source [3:2] and destination [1:0]. With opcode 00, the function field selects the operation: 00 gives dst+src, 01 gives dst-src, 10 gives the low 8 bits of dst*src, and 11 gives dst/src. Division by zero gives 8'hFF.
- R4: With opcode 01, function 00 writes src to dst, 01 writes src+1, 10 writes 0, and 11 writes src unchanged.
- R5: Add, subtract, increment and clear update the zero flag Z and the carry/borrow flag C. C is the carry out for add and increment, is set when dst < src for subtract, and is 0 for clear. Every other instruction leaves both flags unchanged.
- R6: When the upper nibble is not 1100, opcode 11 is a jump to the address in bits [3:0]. Condition field 01 always jumps, 10 jumps when Z=1, and 11 jumps when C=1. A jump whose condition fails goes to PC+1.
- R7: An upper nibble of 1100 marks a stop/IO instruction and takes priority over the jump decode. When bit 2 is 1, the processor stops. `halted_o` then stays 1 and the display stays frozen until reset, even if bit 3 is also 1.
- R8: In a stop/IO instruction with bit 2 equal to 0, bit 3 set to 1 copies `switch_i` into register [1:0] and onto the display. Bit 3 set to 0 puts register [1:0] on the display and leaves the register unchanged.
- R9: Every register write from R3, R4 or R8 also loads the same value into the display. Opcode 10 changes no register, flag or display value.
- R10: A write on the program port stores `pgm_data` at `pgm_addr`. The program counter wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pgm_we | input | 1 | Program store write enable |
| pgm_addr | input | 4 | Program store write address |
| pgm_data | input | 8 | Program store write data |
| switch_i | input | 8 | Switch register value |
| display_o | output | 8 | Display register |
| halted_o | output | 1 | High once a stop instruction has executed |

## Verification
The bench builds the block with its default parameters: 8-bit data, four registers and a 16-word program store. At this size an increment loop can run the working register all the way through its 256 values to its wrap-around in a couple of thousand cycles. This brings the carry and zero outputs of increment, and the jump-on-zero that depends on them, within reach. The same small store also lets a straight-line program cross the 15-to-0 address wrap in a few dozen cycles. A cycle-level behavioural model compares the display and the stopped flag on every clock. Directed programs also check the end results of jumps, division by zero, borrow and the stop-over-load priority.

// File: rtl/mini8_pkg.sv
package mini8_pkg;

    localparam int INSTR_W = 8;
    localparam int PC_W    = 4;

    typedef enum logic [1:0] {
        ST_FETCH  = 2'd0,
        ST_DECODE = 2'd1,
        ST_EXEC   = 2'd2,
        ST_STOP   = 2'd3
    } cpu_state_e;

    // order matters: the index is {opcode[0], function}
    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_MUL  = 3'd2,
        ALU_DIV  = 3'd3,
        ALU_MOV  = 3'd4,
        ALU_INC  = 3'd5,
        ALU_CLR  = 3'd6,
        ALU_PASS = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic [1:0] op;
        logic [1:0] fn;
        logic [1:0] src;
        logic [1:0] dst;
    } instr_t;

    localparam logic [3:0] SYS_PREFIX = 4'b1100;

endpackage

// File: rtl/mini8_progmem.sv
module mini8_progmem #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);

    logic [WORD_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = words_q[rd_addr];

endmodule

// File: rtl/mini8_regfile.sv
module mini8_regfile #(
    parameter int DATA_W  = 8,
    parameter int REG_CNT = 4,
    localparam int RA_W   = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_sel,
    input  logic [DATA_W-1:0] wr_val,
    input  logic [RA_W-1:0]   rd_sel_a,
    output logic [DATA_W-1:0] rd_val_a,
    input  logic [RA_W-1:0]   rd_sel_b,
    output logic [DATA_W-1:0] rd_val_b
);

    logic [REG_CNT-1:0][DATA_W-1:0] regs_d;
    logic [REG_CNT-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && (wr_sel == RA_W'(g))) begin
                regs_d[g] = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else begin
                regs_q[g] <= regs_d[g];
            end
        end
    end

    assign rd_val_a = regs_q[rd_sel_a];
    assign rd_val_b = regs_q[rd_sel_b];

    // registers hold whenever no write is requested (nop and jumps)
    assert_regs_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs_q));

endmodule

// File: rtl/mini8_alu.sv
module mini8_alu
    import mini8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] dst_val,
    input  logic [DATA_W-1:0] src_val,
    output logic [DATA_W-1:0] result,
    output logic              carry,
    output logic              zero,
    output logic              flag_upd
);

    logic [DATA_W:0] wide;

    always_comb begin
        result   = '0;
        carry    = 1'b0;
        flag_upd = 1'b0;
        wide     = '0;
        unique case (op)
            ALU_ADD: begin
                wide     = {1'b0, dst_val} + {1'b0, src_val};
                result   = wide[DATA_W-1:0];
                carry    = wide[DATA_W];
                flag_upd = 1'b1;
            end
            ALU_SUB: begin
                wide     = {1'b0, dst_val} - {1'b0, src_val};
                result   = wide[DATA_W-1:0];
                carry    = wide[DATA_W];
                flag_upd = 1'b1;
            end
            ALU_MUL: result = dst_val * src_val;
            ALU_DIV: result = (src_val == '0) ? '1 : dst_val / src_val;
            ALU_MOV: result = src_val;
            ALU_INC: begin
                wide     = {1'b0, src_val} + {{DATA_W{1'b0}}, 1'b1};
                result   = wide[DATA_W-1:0];
                carry    = wide[DATA_W];
                flag_upd = 1'b1;
            end
            ALU_CLR: begin
                result   = '0;
                flag_upd = 1'b1;
            end
            ALU_PASS: result = src_val;
            default: result = '0;
        endcase
    end

    assign zero = (result == '0);

endmodule

// File: rtl/mini8_core.sv
module mini8_core
    import mini8_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int REG_CNT = 4,
    localparam int RA_W   = $clog2(REG_CNT),
    localparam int DEPTH  = 1 << PC_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pgm_we,
    input  logic [PC_W-1:0]    pgm_addr,
    input  logic [INSTR_W-1:0] pgm_data,
    input  logic [DATA_W-1:0]  switch_i,
    output logic [DATA_W-1:0]  display_o,
    output logic               halted_o
);

    typedef struct packed {
        cpu_state_e        st;
        logic [PC_W-1:0]   pc;
        instr_t            ir;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic              z;
        logic              c;
        logic [DATA_W-1:0] disp;
        logic              halted;
    } core_t;

    core_t core_d, core_q;

    logic [INSTR_W-1:0] imem_word;
    logic               rf_we;
    logic [DATA_W-1:0]  rf_wval;
    logic [DATA_W-1:0]  rf_a, rf_b;
    alu_op_e            alu_op;
    logic [DATA_W-1:0]  alu_res;
    logic               alu_c, alu_z, alu_upd;
    logic               is_sys, jump_ok;

    mini8_progmem #(.WORD_W(INSTR_W), .DEPTH(DEPTH)) u_pmem (
        .clk     (clk),
        .wr_en   (pgm_we),
        .wr_addr (pgm_addr),
        .wr_data (pgm_data),
        .rd_addr (core_q.pc),
        .rd_data (imem_word)
    );

    mini8_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (rf_we),
        .wr_sel   (RA_W'(core_q.ir.dst)),
        .wr_val   (rf_wval),
        .rd_sel_a (RA_W'(core_q.ir.dst)),
        .rd_val_a (rf_a),
        .rd_sel_b (RA_W'(core_q.ir.src)),
        .rd_val_b (rf_b)
    );

    assign alu_op = alu_op_e'({core_q.ir.op[0], core_q.ir.fn});

    mini8_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (alu_op),
        .dst_val  (core_q.opa),
        .src_val  (core_q.opb),
        .result   (alu_res),
        .carry    (alu_c),
        .zero     (alu_z),
        .flag_upd (alu_upd)
    );

    assign is_sys = ({core_q.ir.op, core_q.ir.fn} == SYS_PREFIX);

    always_comb begin
        unique case (core_q.ir.fn)
            2'b01:   jump_ok = 1'b1;
            2'b10:   jump_ok = core_q.z;
            2'b11:   jump_ok = core_q.c;
            default: jump_ok = 1'b0;
        endcase
    end

    always_comb begin
        core_d  = core_q;
        rf_we   = 1'b0;
        rf_wval = '0;
        unique case (core_q.st)
            ST_FETCH: begin
                core_d.ir = instr_t'(imem_word);
                core_d.st = ST_DECODE;
            end
            ST_DECODE: begin
                core_d.opa = rf_a;
                core_d.opb = rf_b;
                core_d.st  = ST_EXEC;
            end
            ST_EXEC: begin
                core_d.st = ST_FETCH;
                core_d.pc = core_q.pc + PC_W'(1);
                if (is_sys) begin
                    if (core_q.ir.src[0]) begin
                        core_d.halted = 1'b1;
                        core_d.st     = ST_STOP;
                        core_d.pc     = core_q.pc;
                    end else if (core_q.ir.src[1]) begin
                        rf_we       = 1'b1;
                        rf_wval     = switch_i;
                        core_d.disp = switch_i;
                    end else begin
                        core_d.disp = core_q.opa;
                    end
                end else if (core_q.ir.op == 2'b11) begin
                    if (jump_ok) begin
                        core_d.pc = {core_q.ir.src, core_q.ir.dst};
                    end
                end else if (core_q.ir.op == 2'b10) begin
                    core_d.disp = core_q.disp;
                end else begin
                    rf_we       = 1'b1;
                    rf_wval     = alu_res;
                    core_d.disp = alu_res;
                    if (alu_upd) begin
                        core_d.z = alu_z;
                        core_d.c = alu_c;
                    end
                end
            end
            default: core_d = core_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign display_o = core_q.disp;
    assign halted_o  = core_q.halted;

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_FETCH) |=> (core_q.st == ST_DECODE));

    assert_decode_then_exec_R2: assert property (@(posedge clk) disable iff (rst)
        (core_q.st == ST_DECODE) |=> (core_q.st == ST_EXEC));

    assert_pc_moves_on_exec_R2: assert property (@(posedge clk) disable iff (rst)
        (core_q.st != ST_EXEC) |=> $stable(core_q.pc));

    assert_disp_moves_on_exec_R9: assert property (@(posedge clk) disable iff (rst)
        (core_q.st != ST_EXEC) |=> $stable(core_q.disp));

    assert_stop_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        core_q.halted |=> (core_q.halted && $stable(core_q.disp)));

    assert_flags_only_alu_R5: assert property (@(posedge clk) disable iff (rst)
        !(core_q.st == ST_EXEC && !core_q.ir.op[1]) |=> ($stable(core_q.z) && $stable(core_q.c)));

endmodule

// File: tb/mini8_core_tb.sv
module mini8_core_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pgm_we = 1'b0;
    logic [3:0] pgm_addr = '0;
    logic [7:0] pgm_data = '0;
    logic [7:0] switch_i = '0;
    logic [7:0] display_o;
    logic       halted_o;

    always #4 clk = ~clk;

    mini8_core u_dut (
        .clk       (clk),
        .rst       (rst),
        .pgm_we    (pgm_we),
        .pgm_addr  (pgm_addr),
        .pgm_data  (pgm_data),
        .switch_i  (switch_i),
        .display_o (display_o),
        .halted_o  (halted_o)
    );

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;

    // behavioural reference
    logic [7:0] m_mem [16];
    int         m_r [4];
    int         m_pc, m_ph, m_disp;
    bit         m_z, m_c, m_halt;
    logic [7:0] m_ir;
    string      m_tag = "R1";

    task automatic model_exec();
        int a, b, t, res, d, s, cc;
        bit take;
        d = int'(m_ir[1:0]);
        s = int'(m_ir[3:2]);
        cc = int'(m_ir[5:4]);
        if (m_ir[7:4] == 4'b1100) begin
            if (m_ir[2]) begin
                m_halt = 1; m_tag = "R7";
            end else if (m_ir[3]) begin
                m_r[d] = int'(switch_i); m_disp = int'(switch_i); m_tag = "R8";
                m_pc = (m_pc + 1) % 16;
            end else begin
                m_disp = m_r[d]; m_tag = "R8";
                m_pc = (m_pc + 1) % 16;
            end
        end else if (m_ir[7:6] == 2'b11) begin
            take = (cc == 1) || (cc == 2 && m_z) || (cc == 3 && m_c);
            m_pc = take ? int'(m_ir[3:0]) : (m_pc + 1) % 16;
            m_tag = "R6";
        end else if (m_ir[7:6] == 2'b10) begin
            m_pc = (m_pc + 1) % 16; m_tag = "R9";
        end else begin
            a = m_r[d]; b = m_r[s]; res = 0;
            case ({m_ir[6], m_ir[5:4]})
                3'd0: begin t = a + b; res = t % 256; m_c = (t > 255); m_z = (res == 0); end
                3'd1: begin res = (a - b + 256) % 256; m_c = (a < b); m_z = (res == 0); end
                3'd2: res = (a * b) % 256;
                3'd3: res = (b == 0) ? 255 : a / b;
                3'd4: res = b;
                3'd5: begin t = b + 1; res = t % 256; m_c = (t > 255); m_z = (res == 0); end
                3'd6: begin res = 0; m_c = 0; m_z = 1; end
                default: res = b;
            endcase
            m_r[d] = res; m_disp = res;
            m_tag = m_ir[6] ? "R4" : "R3";
            m_pc = (m_pc + 1) % 16;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_pc = 0; m_ph = 0; m_disp = 0; m_z = 0; m_c = 0; m_halt = 0;
            for (int i = 0; i < 4; i++) m_r[i] = 0;
        end else if (!m_halt) begin
            case (m_ph)
                0: begin m_ir = m_mem[m_pc]; m_ph = 1; end
                1: m_ph = 2;
                default: begin model_exec(); m_ph = 0; end
            endcase
        end
        if (pgm_we) m_mem[pgm_addr] = pgm_data;
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (!rst) begin
            vectors++;
            if (display_o !== 8'(m_disp)) begin
                errors++;
                $display("FAIL %s display: got %h expected %h", m_tag, display_o, 8'(m_disp));
            end
            vectors++;
            if (halted_o !== m_halt) begin
                errors++;
                $display("FAIL %s halted: got %b expected %b", m_tag, halted_o, m_halt);
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] prog_word(input int p, input int i);
        logic [7:0] w;
        w = 8'hC4;
        case (p)
            0: case (i)
                0: w = 8'hC8;  1: w = 8'h41;  2: w = 8'h56;  3: w = 8'h09;
                4: w = 8'h21;  5: w = 8'h39;  6: w = 8'h63;  7: w = 8'h3C;
                8: w = 8'hEA;  9: w = 8'hC4; 10: w = 8'hC1; 11: w = 8'h80;
               12: w = 8'h18; 13: w = 8'hF0; 14: w = 8'hC0; default: w = 8'hC4;
               endcase
            1: case (i)
                0: w = 8'hC8;  1: w = 8'h63;  2: w = 8'h13;  3: w = 8'hF6;
                6: w = 8'hCC;  default: w = 8'hC4;
               endcase
            2: w = 8'h50;
            3: case (i)
                0: w = 8'h50;  1: w = 8'hE3;  2: w = 8'hD0;  3: w = 8'hC0;
                default: w = 8'hC4;
               endcase
            default: case (i)
                0: w = 8'hC8;  1: w = 8'h71;  2: w = 8'h01;  3: w = 8'hF5;
                5: w = 8'h56;  6: w = 8'hEF;  7: w = 8'hFF;  8: w = 8'hC2;
               15: w = 8'hC0;  default: w = 8'hC4;
               endcase
        endcase
        return w;
    endfunction

    task automatic load_and_start(input int p, input logic [7:0] sw);
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            pgm_we = 1'b1; pgm_addr = 4'(i); pgm_data = prog_word(p, i);
            @(negedge clk);
        end
        pgm_we = 1'b0;
        switch_i = sw;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        // watchdog
        while (cycles < 150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 display after reset", display_o, 8'h00);
        check("R1 halted after reset", {7'b0, halted_o}, 8'h00);
        rst = 1'b1;

        // arithmetic, division by zero, jump on Z, output, nop, borrow
        load_and_start(0, 8'h07);
        run(60);
        check("R3 final display", display_o, 8'hF7);
        check("R7 stopped", {7'b0, halted_o}, 8'h01);

        // borrow jump, stop takes priority over switch load
        load_and_start(1, 8'h03);
        run(10);
        switch_i = 8'h55;
        run(20);
        check("R5 borrow result on display", display_o, 8'hFD);
        check("R7 stop wins over load", {7'b0, halted_o}, 8'h01);
        check("R8 switch not loaded on stop", display_o, 8'hFD);

        // straight line across the address wrap
        load_and_start(2, 8'h00);
        run(59);
        check("R2 before 20th completion", display_o, 8'd19);
        run(1);
        check("R10 after wrap, 20 increments", display_o, 8'd20);
        run(2);
        check("R2 display held mid-instruction", display_o, 8'd20);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 mid-run reset clears display", display_o, 8'h00);
        check("R1 mid-run reset, running", {7'b0, halted_o}, 8'h00);

        // increment loop through wrap, jump on Z
        load_and_start(3, 8'h00);
        run(2400);
        check("R6 loop exit on Z display", display_o, 8'h00);
        check("R6 loop exit stopped", {7'b0, halted_o}, 8'h01);

        // pass, add carry, untaken jumps, increment
        load_and_start(4, 8'h90);
        run(40);
        check("R4 pass/inc result", display_o, 8'h21);
        check("R9 stopped after output", {7'b0, halted_o}, 8'h01);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule